// File: doc/BRIEF.md
# User-Level Timer Access Gate

This block decides, for each access that software running at the lowest privilege level makes to a timer or counter resource, whether the access may proceed or must be trapped to a more privileged level. The resource is given as a small class code, and four permission bits (one per resource family) say which families user code may touch. The privilege level of the access and three hypervisor flags (host mode, trap-general, level 2 present and enabled) complete the inputs.

The verdict is a trap flag and a 2-bit target level: level 1 by default, level 2 when level 2 is enabled and the trap-general flag is set. When host mode and trap-general are both set, this gate is out of the picture and never traps. Accesses made above level 0, and cycles without a valid access, never trap. A build parameter picks a purely combinational verdict or one registered stage; the default is registered, so the verdict follows its access by one clock.

Top module: `tmr_user_gate`

## Requirements
- R1: Class codes are 0 = physical counter, 1 = virtual counter, 2 = frequency register, 3 = virtual timer, 4 = physical timer; permission bits are perm_i[0] physical counter, perm_i[1] virtual counter, perm_i[2] virtual timer, perm_i[3] physical timer. A valid level-0 access to a counter or timer class whose permission bit is 0 traps, unless R5 applies.
- R2: A valid level-0 access to a counter or timer class whose permission bit is 1 does not trap.
- R3: A frequency register access (class 2) traps only when perm_i[0] and perm_i[1] are both 0; either bit at 1 lets it through.
- R4: When trapping, tgt_o is 2 if l2_on_i and tgen_i are both 1, and 1 otherwise.
- R5: When host_i and tgen_i are both 1, trap_o is 0 for every access.
- R6: An access at level 1, 2 or 3 (acc_lvl_i not 0) never traps.
- R7: trap_o is 0 in any verdict whose access had acc_valid_i low.
- R8: tgt_o is 0 whenever trap_o is 0.
- R9: With REG_OUT = 1 (default) the verdict appears one clock after the access is presented; while rst is high at a clock edge, trap_o and tgt_o become 0.
- R10: Class codes 5, 6 and 7 never trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (used by the registered variant) |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_cls_i | input | 3 | Resource class code |
| acc_lvl_i | input | 2 | Privilege level of the access |
| perm_i | input | 4 | User permission bits, one per resource family |
| host_i | input | 1 | Hypervisor host-mode flag |
| tgen_i | input | 1 | Hypervisor trap-general flag |
| l2_on_i | input | 1 | Level 2 present and enabled for this state |
| trap_o | output | 1 | Access must be trapped |
| tgt_o | output | 2 | Level the trap goes to (0 when no trap) |

## Verification
The bench sweeps every combination of class, permission bits, level, hypervisor flags and valid, so the frequency register with exactly one counter bit open, host mode without trap-general, and trap-general without level 2 all appear. A design that tied the frequency register to a single counter bit would trap with the other bit open; one that bypassed on host mode alone would miss traps; one that routed on trap-general without the level-2 enable would report target 2 instead of 1. Reserved class codes, raised levels and idle cycles catch a gate that traps on a stale or default decode, and accesses held during reset catch an output stage that lets a verdict through before reset releases.

// File: rtl/tmr_gate_pkg.sv
`timescale 1ns/1ps
package tmr_gate_pkg;

    localparam int CLS_W  = 3;
    localparam int LVL_W  = 2;
    localparam int PERM_W = 4;
    localparam int TGT_W  = 2;

    // Permission vector bit positions
    localparam int P_PCNT = 0;
    localparam int P_VCNT = 1;
    localparam int P_VTMR = 2;
    localparam int P_PTMR = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_PCNT = 3'd0,
        CLS_VCNT = 3'd1,
        CLS_FREQ = 3'd2,
        CLS_VTMR = 3'd3,
        CLS_PTMR = 3'd4
    } res_cls_e;

    typedef enum logic [LVL_W-1:0] {
        LVL_USER = 2'd0,
        LVL_KERN = 2'd1,
        LVL_HYP  = 2'd2,
        LVL_MON  = 2'd3
    } lvl_e;

    typedef enum logic [TGT_W-1:0] {
        TGT_NONE = 2'd0,
        TGT_KERN = 2'd1,
        TGT_HYP  = 2'd2
    } tgt_e;

    typedef struct packed {
        logic host;
        logic tgen;
        logic l2_on;
    } hyp_flags_t;

    typedef struct packed {
        logic trap;
        tgt_e tgt;
    } verdict_t;

    localparam verdict_t VERDICT_IDLE = '{trap: 1'b0, tgt: TGT_NONE};

    // Map a single-family class code to the permission bit that governs it.
    // Returns PERM_W for classes that are not governed by one bit.
    function automatic int perm_index(input logic [CLS_W-1:0] cls);
        case (cls)
            CLS_PCNT: return P_PCNT;
            CLS_VCNT: return P_VCNT;
            CLS_VTMR: return P_VTMR;
            CLS_PTMR: return P_PTMR;
            default:  return PERM_W;
        endcase
    endfunction

endpackage

// File: rtl/tmr_res_check.sv
`timescale 1ns/1ps
module tmr_res_check
    import tmr_gate_pkg::*;
(
    input  logic [CLS_W-1:0]  cls_i,
    input  logic [PERM_W-1:0] perm_i,
    output logic              denied_o
);

    // One "closed" flag per permission-governed class
    logic [PERM_W-1:0] closed;

    for (genvar g = 0; g < PERM_W; g++) begin : g_fam
        logic hit;
        assign hit       = (perm_index(cls_i) == g);
        assign closed[g] = hit & ~perm_i[g];
    end

    logic freq_closed;
    assign freq_closed = (cls_i == CLS_FREQ) & ~perm_i[P_PCNT] & ~perm_i[P_VCNT];

    always_comb begin
        denied_o = (|closed) | freq_closed;
    end

endmodule

// File: rtl/tmr_route_sel.sv
`timescale 1ns/1ps
module tmr_route_sel
    import tmr_gate_pkg::*;
(
    input  hyp_flags_t flags_i,
    output logic       bypass_o,
    output tgt_e       tgt_o
);

    always_comb begin
        bypass_o = flags_i.host & flags_i.tgen;
        if (flags_i.l2_on && flags_i.tgen) begin
            tgt_o = TGT_HYP;
        end else begin
            tgt_o = TGT_KERN;
        end
    end

endmodule

// File: rtl/tmr_out_stage.sv
`timescale 1ns/1ps
module tmr_out_stage
    import tmr_gate_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  verdict_t vin_i,
    output verdict_t vout_o
);

    if (REG_OUT) begin : g_reg
        verdict_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= VERDICT_IDLE;
            end else begin
                q <= vin_i;
            end
        end
        assign vout_o = q;
    end else begin : g_comb
        logic unused_clk_rst;
        assign unused_clk_rst = clk ^ rst;
        assign vout_o = vin_i;
    end

endmodule

// File: rtl/tmr_user_gate.sv
`timescale 1ns/1ps
module tmr_user_gate
    import tmr_gate_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid_i,
    input  logic [CLS_W-1:0]  acc_cls_i,
    input  logic [LVL_W-1:0]  acc_lvl_i,
    input  logic [PERM_W-1:0] perm_i,
    input  logic              host_i,
    input  logic              tgen_i,
    input  logic              l2_on_i,
    output logic              trap_o,
    output logic [TGT_W-1:0]  tgt_o
);

    hyp_flags_t flags;
    logic       denied;
    logic       bypass;
    tgt_e       route;
    logic       user_acc;
    verdict_t   v_now;
    verdict_t   v_out;

    assign flags = '{host: host_i, tgen: tgen_i, l2_on: l2_on_i};

    tmr_res_check u_res (
        .cls_i    (acc_cls_i),
        .perm_i   (perm_i),
        .denied_o (denied)
    );

    tmr_route_sel u_route (
        .flags_i  (flags),
        .bypass_o (bypass),
        .tgt_o    (route)
    );

    assign user_acc = acc_valid_i && (acc_lvl_i == LVL_USER);

    always_comb begin
        v_now = VERDICT_IDLE;
        if (user_acc && !bypass && denied) begin
            v_now.trap = 1'b1;
            v_now.tgt  = route;
        end
    end

    tmr_out_stage #(.REG_OUT(REG_OUT)) u_out (
        .clk    (clk),
        .rst    (rst),
        .vin_i  (v_now),
        .vout_o (v_out)
    );

    assign trap_o = v_out.trap;
    assign tgt_o  = v_out.tgt;

    // R8
    tgt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !trap_o |-> (tgt_o == TGT_NONE));

    // R4
    tgt_range_chk: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> (tgt_o == TGT_KERN || tgt_o == TGT_HYP));

    if (REG_OUT) begin : g_chk_reg
        // R7
        valid_gate_chk: assert property (@(posedge clk) disable iff (rst)
            trap_o |-> $past(acc_valid_i));
        // R6
        lvl_gate_chk: assert property (@(posedge clk) disable iff (rst)
            trap_o |-> ($past(acc_lvl_i) == LVL_USER));
        // R5
        host_bypass_chk: assert property (@(posedge clk) disable iff (rst)
            trap_o |-> !($past(host_i) && $past(tgen_i)));
        // R4
        tgt_l2_chk: assert property (@(posedge clk) disable iff (rst)
            (trap_o && tgt_o == TGT_HYP) |-> ($past(l2_on_i) && $past(tgen_i)));
        // R10
        cls_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
            trap_o |-> ($past(acc_cls_i) <= CLS_PTMR));
    end else begin : g_chk_comb
        // R7
        valid_gate_chk: assert property (@(posedge clk) disable iff (rst)
            trap_o |-> acc_valid_i);
        // R6
        lvl_gate_chk: assert property (@(posedge clk) disable iff (rst)
            trap_o |-> (acc_lvl_i == LVL_USER));
        // R5
        host_bypass_chk: assert property (@(posedge clk) disable iff (rst)
            trap_o |-> !(host_i && tgen_i));
        // R4
        tgt_l2_chk: assert property (@(posedge clk) disable iff (rst)
            (trap_o && tgt_o == TGT_HYP) |-> (l2_on_i && tgen_i));
        // R10
        cls_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
            trap_o |-> (acc_cls_i <= CLS_PTMR));
    end

endmodule

// File: tb/sim_tmr_user_gate.sv
`timescale 1ns/1ps
module sim_tmr_user_gate;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acc_valid_i = 1'b0;
    logic [2:0] acc_cls_i = 3'd0;
    logic [1:0] acc_lvl_i = 2'd0;
    logic [3:0] perm_i = 4'd0;
    logic       host_i = 1'b0;
    logic       tgen_i = 1'b0;
    logic       l2_on_i = 1'b0;
    logic       trap_o;
    logic [1:0] tgt_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic       trap;
        logic [1:0] tgt;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_user_gate u0 (
        .clk         (clk),
        .rst         (rst),
        .acc_valid_i (acc_valid_i),
        .acc_cls_i   (acc_cls_i),
        .acc_lvl_i   (acc_lvl_i),
        .perm_i      (perm_i),
        .host_i      (host_i),
        .tgen_i      (tgen_i),
        .l2_on_i     (l2_on_i),
        .trap_o      (trap_o),
        .tgt_o       (tgt_o)
    );

    // Reference model built from the requirement text
    function automatic exp_t model(input logic v, input logic [2:0] c, input logic [1:0] l,
                                   input logic [3:0] p, input logic h, input logic t,
                                   input logic e);
        exp_t r;
        logic open_bit;
        r.trap = 1'b0;
        r.tgt  = 2'd0;
        if (!v)             begin r.tag = "R7";  return r; end
        if (l != 2'd0)      begin r.tag = "R6";  return r; end
        if (h && t)         begin r.tag = "R5";  return r; end
        if (c > 3'd4)       begin r.tag = "R10"; return r; end
        case (c)
            3'd0: open_bit = p[0];
            3'd1: open_bit = p[1];
            3'd2: open_bit = p[0] | p[1];
            3'd3: open_bit = p[2];
            default: open_bit = p[3];
        endcase
        if (open_bit) begin
            r.tag = (c == 3'd2) ? "R3" : "R2";
            return r;
        end
        r.trap = 1'b1;
        r.tgt  = (e && t) ? 2'd2 : 2'd1;
        r.tag  = (c == 3'd2) ? "R3/R4" : "R1/R4";
        return r;
    endfunction

    // Driver: apply at the falling edge, push expectation for the next rising edge
    task automatic drive(input logic v, input logic [2:0] c, input logic [1:0] l,
                         input logic [3:0] p, input logic h, input logic t, input logic e);
        exp_t x;
        @(negedge clk);
        acc_valid_i = v; acc_cls_i = c; acc_lvl_i = l; perm_i = p;
        host_i = h; tgen_i = t; l2_on_i = e;
        if (rst) begin
            x.trap = 1'b0; x.tgt = 2'd0; x.tag = "R9";
        end else begin
            x = model(v, c, l, p, h, t, e);
        end
        sb.push_back(x);
    endtask

    // Monitor: one clock after the access, sample just past the edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t x;
            x = sb.pop_front();
            total++;
            if (trap_o !== x.trap) begin
                bad++;
                $display("FAIL %s trap: got %0b expected %0b", x.tag, trap_o, x.trap);
            end
            total++;
            if (tgt_o !== x.tgt) begin
                bad++;
                $display("FAIL %s/R8 target: got %0d expected %0d", x.tag, tgt_o, x.tgt);
            end
        end
    end

    initial begin
        // R9: trapping accesses held in reset give an idle verdict
        drive(1'b1, 3'd0, 2'd0, 4'h0, 1'b0, 1'b1, 1'b1);
        drive(1'b1, 3'd4, 2'd0, 4'h0, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 3'd2, 2'd0, 4'h0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        rst = 1'b0;
        // R9: one-clock latency, verdict of the first access after release
        drive(1'b1, 3'd3, 2'd0, 4'h0, 1'b0, 1'b0, 1'b0);
        // Exhaustive sweep covering R1..R8 and R10
        for (int f = 0; f < 8; f++) begin
            for (int l = 0; l < 4; l++) begin
                for (int c = 0; c < 8; c++) begin
                    for (int p = 0; p < 16; p++) begin
                        for (int v = 0; v < 2; v++) begin
                            drive(v[0], c[2:0], l[1:0], p[3:0], f[2], f[1], f[0]);
                        end
                    end
                end
            end
        end
        // R3: frequency register with exactly one counter bit open, back to back
        drive(1'b1, 3'd2, 2'd0, 4'b0001, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 3'd2, 2'd0, 4'b0010, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 3'd2, 2'd0, 4'b1100, 1'b0, 1'b1, 1'b1);
        drive(1'b0, 3'd0, 2'd0, 4'b0000, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule